// File: doc/BRIEF.md
# Chained Queue Almost-Empty Status Bus Scanner

This block puts the almost-empty flags of a group of queues onto a narrow shared status bus. The flags are grouped into status words, and each word carries the flags of a pair of queues. Several copies of the block can share one bus. They are wired in a ring through a token input and a token output, and only the copy that holds the token drives its words. A copy that does not hold the token drives zeros with its bus-enable low, so the buses of the chain can be ORed together.

In polled mode, the copy that holds the token puts out one word per read clock edge, words 1 to 4 in turn. A sync output is high while word 1 is on the bus. The token output is high while word 4 is on the bus, and the next copy in the ring takes over on the following edge. A single copy in polled mode feeds its token output back to its own token input, so it wraps from word 4 to word 1 with no gap. In direct mode, the token is not used. A strobe loads the word chosen by an address, but only after a programming-done input has been raised.

The control is a four-state machine. ST_IDLE means no token. ST_ARMED means the copy holds the token after reset and is the head of the chain. ST_SCAN means the copy is driving polled words. ST_DIRECT means direct mode. The transitions are:
- take_token: ST_IDLE to ST_SCAN when the token input is high.
- start_scan: ST_ARMED to ST_SCAN.
- step: ST_SCAN to ST_SCAN, moving to the next word or wrapping from word 4 to word 1 when the token input is high.
- release: ST_SCAN to ST_IDLE after word 4 when the token input is low.
- enter_direct: any state to ST_DIRECT when the mode input goes high.
- leave_direct: ST_DIRECT to ST_ARMED (head copy) or to ST_IDLE (other copies) when the mode input goes low.

Top module: `qsb_status_scanner`

## Requirements
- R1: While reset is asserted, stat_bus is 0, and bus_en, word_sync and tok_out are all low.
- R2: In polled mode, the head copy (CHAIN_HEAD=1) loads word 1 on the first edge after reset, then words 2, 3 and 4 on the three edges that follow. Word k (1..4) puts q_flags[2k-2] on stat_bus[0] and q_flags[2k-1] on stat_bus[1], sampled on the edge that loads it.
- R3: word_sync is high exactly during the cycles in which word 1 is on the bus in polled mode.
- R4: tok_out is high exactly during the cycles in which word 4 is on the bus in polled mode.
- R5: An idle copy that sees tok_in high on an edge loads word 1 on that same edge. A copy that held word 4 and sees tok_in low goes idle: bus_en low and stat_bus 0.
- R6: A copy that holds word 4 and sees tok_in high on an edge loads word 1 on that edge, which is the single-copy loopback wrap.
- R7: In direct mode, an edge with sel_strobe and prog_done both high loads word sel_addr+1 (sel_addr is the 0-based word index) with bus_en high. In direct mode word_sync and tok_out stay low.
- R8: In direct mode, sel_strobe has no effect while prog_done is low, and stat_bus holds its value on edges where sel_strobe is low.
- R9: In polled mode, sel_strobe, sel_addr and prog_done have no effect on the word sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_mode | input | 1 | 1 = direct mode, 0 = polled mode |
| prog_done | input | 1 | Programming finished; enables direct-mode strobes |
| q_flags | input | 8 | Almost-empty flags; bit i belongs to queue i |
| sel_addr | input | 2 | Direct-mode word index (0 = word 1) |
| sel_strobe | input | 1 | Direct-mode load strobe |
| tok_in | input | 1 | Token from the previous copy in the ring |
| tok_out | output | 1 | Token to the next copy; high while word 4 is on the bus |
| word_sync | output | 1 | High while word 1 is on the bus |
| stat_bus | output | 2 | Status word; zero when not driving |
| bus_en | output | 1 | High when this copy is driving stat_bus |

## Verification
stat_bus, bus_en and word_sync come from registers and change on the edge that samples the flags, the token, the strobe and the address. A stimulus therefore shows at the outputs one edge later. tok_out comes from the registered state and the word index, so it rises in the same cycle that word 4 appears, and the next copy's word 1 follows one edge after that. The bench drives every input 1 ns after a rising edge and compares all outputs 1 ns after the next rising edge. It compares them against a slot model in which global slot n belongs to copy (n/4) mod 3 and to word (n mod 4)+1, using the flags that were driven before that edge.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SCAN   = 2'd2,
        ST_DIRECT = 2'd3
    } scan_state_e;
endpackage

// File: rtl/qsb_word_mux.sv
module qsb_word_mux #(
    parameter int NUM_WORDS      = 4,
    parameter int FLAGS_PER_WORD = 2,
    parameter int IDX_W          = $clog2(NUM_WORDS)
) (
    input  logic [NUM_WORDS*FLAGS_PER_WORD-1:0] flags,
    input  logic [IDX_W-1:0]                    sel,
    output logic [FLAGS_PER_WORD-1:0]           word
);
    logic [FLAGS_PER_WORD-1:0] slices [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
        assign slices[g] = flags[g*FLAGS_PER_WORD +: FLAGS_PER_WORD];
    end

    assign word = slices[sel];
endmodule

// File: rtl/qsb_scan_fsm.sv
module qsb_scan_fsm
    import qsb_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter bit CHAIN_HEAD = 1'b0,
    parameter int IDX_W      = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             direct_mode,
    input  logic             prog_done,
    input  logic             sel_strobe,
    input  logic [IDX_W-1:0] sel_addr,
    input  logic             tok_in,
    output scan_state_e      state,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic [IDX_W-1:0] load_idx,
    output logic             load_sync,
    output logic             clear
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam scan_state_e      RST_ST   = CHAIN_HEAD ? ST_ARMED : ST_IDLE;

    scan_state_e      nxt_state;
    logic [IDX_W-1:0] nxt_idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RST_ST;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
        end
    end

    // Next state and load decisions
    always_comb begin
        nxt_state = state;
        load      = 1'b0;
        load_idx  = idx;
        load_sync = 1'b0;
        clear     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (direct_mode) begin
                    nxt_state = ST_DIRECT;          // enter_direct
                    clear     = 1'b1;
                end else if (tok_in) begin
                    nxt_state = ST_SCAN;            // take_token
                    load      = 1'b1;
                    load_idx  = '0;
                    load_sync = 1'b1;
                end
            end
            ST_ARMED: begin
                if (direct_mode) begin
                    nxt_state = ST_DIRECT;          // enter_direct
                    clear     = 1'b1;
                end else begin
                    nxt_state = ST_SCAN;            // start_scan
                    load      = 1'b1;
                    load_idx  = '0;
                    load_sync = 1'b1;
                end
            end
            ST_SCAN: begin
                if (direct_mode) begin
                    nxt_state = ST_DIRECT;          // enter_direct
                    clear     = 1'b1;
                end else if (idx != LAST_IDX) begin
                    load      = 1'b1;               // step
                    load_idx  = idx + 1'b1;
                end else if (tok_in) begin
                    load      = 1'b1;               // step (wrap)
                    load_idx  = '0;
                    load_sync = 1'b1;
                end else begin
                    nxt_state = ST_IDLE;            // release
                    clear     = 1'b1;
                end
            end
            ST_DIRECT: begin
                if (!direct_mode) begin
                    nxt_state = RST_ST;             // leave_direct
                    clear     = 1'b1;
                end else if (sel_strobe && prog_done) begin
                    load      = 1'b1;
                    load_idx  = sel_addr;
                end
            end
            default: begin
                nxt_state = RST_ST;
                clear     = 1'b1;
            end
        endcase
        nxt_idx = load ? load_idx : idx;
    end
endmodule

// File: rtl/qsb_bus_reg.sv
module qsb_bus_reg #(
    parameter int FLAGS_PER_WORD = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      clear,
    input  logic                      load_sync,
    input  logic [FLAGS_PER_WORD-1:0] word,
    output logic [FLAGS_PER_WORD-1:0] stat_bus,
    output logic                      bus_en,
    output logic                      word_sync
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_bus  <= '0;
            bus_en    <= 1'b0;
            word_sync <= 1'b0;
        end else if (clear) begin
            stat_bus  <= '0;
            bus_en    <= 1'b0;
            word_sync <= 1'b0;
        end else if (load) begin
            stat_bus  <= word;
            bus_en    <= 1'b1;
            word_sync <= load_sync;
        end
    end
endmodule

// File: rtl/qsb_status_scanner.sv
module qsb_status_scanner
    import qsb_pkg::*;
#(
    parameter int NUM_WORDS      = 4,
    parameter int FLAGS_PER_WORD = 2,
    parameter bit CHAIN_HEAD     = 1'b0,
    parameter int IDX_W          = $clog2(NUM_WORDS),
    parameter int NUM_Q          = NUM_WORDS * FLAGS_PER_WORD
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      direct_mode,
    input  logic                      prog_done,
    input  logic [NUM_Q-1:0]          q_flags,
    input  logic [IDX_W-1:0]          sel_addr,
    input  logic                      sel_strobe,
    input  logic                      tok_in,
    output logic                      tok_out,
    output logic                      word_sync,
    output logic [FLAGS_PER_WORD-1:0] stat_bus,
    output logic                      bus_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    scan_state_e               state;
    logic [IDX_W-1:0]          idx;
    logic                      load;
    logic [IDX_W-1:0]          load_idx;
    logic                      load_sync;
    logic                      clear;
    logic [FLAGS_PER_WORD-1:0] word;

    qsb_scan_fsm #(
        .NUM_WORDS (NUM_WORDS),
        .CHAIN_HEAD(CHAIN_HEAD),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_mode(direct_mode),
        .prog_done  (prog_done),
        .sel_strobe (sel_strobe),
        .sel_addr   (sel_addr),
        .tok_in     (tok_in),
        .state      (state),
        .idx        (idx),
        .load       (load),
        .load_idx   (load_idx),
        .load_sync  (load_sync),
        .clear      (clear)
    );

    qsb_word_mux #(
        .NUM_WORDS     (NUM_WORDS),
        .FLAGS_PER_WORD(FLAGS_PER_WORD),
        .IDX_W         (IDX_W)
    ) u_mux (
        .flags(q_flags),
        .sel  (load_idx),
        .word (word)
    );

    qsb_bus_reg #(
        .FLAGS_PER_WORD(FLAGS_PER_WORD)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .clear    (clear),
        .load_sync(load_sync),
        .word     (word),
        .stat_bus (stat_bus),
        .bus_en   (bus_en),
        .word_sync(word_sync)
    );

    // Token output: last word held in polled scan
    always_comb begin
        tok_out = (state == ST_SCAN) && (idx == LAST_IDX);
    end
endmodule

// File: rtl/qsb_scan_checker.sv
module qsb_scan_checker #(
    parameter int FLAGS_PER_WORD = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      direct_mode,
    input logic                      prog_done,
    input logic                      sel_strobe,
    input logic                      tok_in,
    input logic                      tok_out,
    input logic                      word_sync,
    input logic [FLAGS_PER_WORD-1:0] stat_bus,
    input logic                      bus_en
);
    // R5: a copy that is not driving puts zeros on the shared bus
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (stat_bus == '0));

    // R3 R4: word 1 and word 4 never share a cycle
    a_r4_sync_tok_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_sync, tok_out}));

    // R3: the sync marker only appears while the bus is driven
    a_r3_sync_driven: assert property (@(posedge clk) disable iff (!rst_n)
        word_sync |-> bus_en);

    // R5: handing the token off with no token coming back frees the bus
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && tok_out && !tok_in) |=> !bus_en);

    // R5 R6: an arriving token starts word 1 on the next cycle
    a_r6_pickup: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && tok_in && (!bus_en || tok_out)) |=> (bus_en && word_sync));

    // R8: strobes are locked out before programming is done
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && !prog_done && !bus_en) |=> !bus_en);

    // R8: no strobe means the direct-mode bus holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && $past(direct_mode) && !sel_strobe) |=>
        (!direct_mode || $stable(stat_bus)));

    // R7: direct mode never raises sync or the token
    a_r7_direct_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && $past(direct_mode)) |-> (!word_sync && !tok_out));
endmodule

bind qsb_status_scanner qsb_scan_checker #(
    .FLAGS_PER_WORD(FLAGS_PER_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .direct_mode(direct_mode),
    .prog_done  (prog_done),
    .sel_strobe (sel_strobe),
    .tok_in     (tok_in),
    .tok_out    (tok_out),
    .word_sync  (word_sync),
    .stat_bus   (stat_bus),
    .bus_en     (bus_en)
);

// File: tb/sim_qsb_status_scanner.sv
`timescale 1ns/1ps
module sim_qsb_status_scanner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       direct_mode = 1'b0;
    logic       prog_done = 1'b0;
    logic [1:0] sel_addr = '0;
    logic       sel_strobe = 1'b0;
    logic [7:0] fl [4];
    logic [1:0] bus [4];
    logic       en [4];
    logic       sy [4];
    logic       tk [4];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    // Ring of three copies, u0 at the head
    qsb_status_scanner #(.CHAIN_HEAD(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .prog_done(prog_done),
        .q_flags(fl[0]), .sel_addr(sel_addr), .sel_strobe(sel_strobe),
        .tok_in(tk[2]), .tok_out(tk[0]), .word_sync(sy[0]), .stat_bus(bus[0]), .bus_en(en[0]));
    qsb_status_scanner #(.CHAIN_HEAD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .prog_done(prog_done),
        .q_flags(fl[1]), .sel_addr(sel_addr), .sel_strobe(sel_strobe),
        .tok_in(tk[0]), .tok_out(tk[1]), .word_sync(sy[1]), .stat_bus(bus[1]), .bus_en(en[1]));
    qsb_status_scanner #(.CHAIN_HEAD(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .prog_done(prog_done),
        .q_flags(fl[2]), .sel_addr(sel_addr), .sel_strobe(sel_strobe),
        .tok_in(tk[1]), .tok_out(tk[2]), .word_sync(sy[2]), .stat_bus(bus[2]), .bus_en(en[2]));
    // Single copy with its token looped back to itself
    qsb_status_scanner #(.CHAIN_HEAD(1'b1)) u3 (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .prog_done(prog_done),
        .q_flags(fl[3]), .sel_addr(sel_addr), .sel_strobe(sel_strobe),
        .tok_in(tk[3]), .tok_out(tk[3]), .word_sync(sy[3]), .stat_bus(bus[3]), .bus_en(en[3]));

    function automatic logic [1:0] word_of(input logic [7:0] f, input int w);
        return f[2*w +: 2];
    endfunction

    task automatic check(input string tag, input int d, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s dev=%0d actual=%0d expected=%0d t=%0t", tag, d, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic dm);
        rst_n = 1'b0;
        direct_mode = dm;
        step();
        step();
        rst_n = 1'b1;
    endtask

    logic [7:0] held [4];
    logic [1:0] exp_bus [4];
    logic       exp_en [4];

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);
        for (int d = 0; d < 4; d++) fl[d] = 8'h00;
        step();
        // R1: reset state
        for (int d = 0; d < 4; d++) begin
            check("R1 bus", d, int'(bus[d]), 0);
            check("R1 en", d, int'(en[d]), 0);
            check("R1 sync", d, int'(sy[d]), 0);
            check("R1 tok", d, int'(tk[d]), 0);
        end
        do_reset(1'b0);

        // Polled phase: slot n (0-based) belongs to copy (n/4)%3, word n%4
        for (int n = 0; n < 72; n++) begin
            for (int d = 0; d < 4; d++) begin
                if (n < 4) held[d] = 8'(n == 0 ? 8'hA5 : (n == 1 ? 8'h5A : 8'hFF));
                else       held[d] = 8'($urandom);
                fl[d] = held[d];
            end
            sel_strobe = 1'($urandom);
            sel_addr   = 2'($urandom);
            prog_done  = 1'($urandom);
            step();
            begin
                int owner;
                int w;
                owner = (n / 4) % 3;
                w = n % 4;
                for (int d = 0; d < 3; d++) begin
                    if (d == owner) begin
                        check(sel_strobe ? "R9 bus" : "R2 bus", d, int'(bus[d]), int'(word_of(held[d], w)));
                        check("R5 en", d, int'(en[d]), 1);
                        check("R3 sync", d, int'(sy[d]), int'(w == 0));
                        check("R4 tok", d, int'(tk[d]), int'(w == 3));
                    end else begin
                        check("R5 idle bus", d, int'(bus[d]), 0);
                        check("R5 idle en", d, int'(en[d]), 0);
                        check("R3 idle sync", d, int'(sy[d]), 0);
                        check("R4 idle tok", d, int'(tk[d]), 0);
                    end
                end
                check("R6 wrap bus", 3, int'(bus[3]), int'(word_of(held[3], w)));
                check("R6 wrap en", 3, int'(en[3]), 1);
                check("R6 sync", 3, int'(sy[3]), int'(w == 0));
                check("R6 tok", 3, int'(tk[3]), int'(w == 3));
            end
        end

        // Direct phase
        sel_strobe = 1'b0;
        prog_done  = 1'b0;
        do_reset(1'b1);
        step();
        for (int d = 0; d < 4; d++) begin
            exp_bus[d] = '0;
            exp_en[d]  = 1'b0;
        end
        // R8: strobes locked out before programming completes
        for (int n = 0; n < 4; n++) begin
            sel_strobe = 1'b1;
            sel_addr   = 2'(n);
            for (int d = 0; d < 4; d++) fl[d] = 8'($urandom) | 8'h55;
            step();
            for (int d = 0; d < 4; d++) begin
                check("R8 locked bus", d, int'(bus[d]), 0);
                check("R8 locked en", d, int'(en[d]), 0);
            end
        end
        prog_done = 1'b1;
        for (int n = 0; n < 60; n++) begin
            if (n == 0)      begin sel_strobe = 1'b1; sel_addr = 2'd3; end
            else if (n == 1) begin sel_strobe = 1'b1; sel_addr = 2'd0; end
            else if (n == 2) begin sel_strobe = 1'b0; end
            else begin
                sel_strobe = 1'($urandom);
                sel_addr   = 2'($urandom);
            end
            for (int d = 0; d < 4; d++) begin
                held[d] = 8'($urandom);
                fl[d] = held[d];
                if (sel_strobe) begin
                    exp_bus[d] = word_of(held[d], int'(sel_addr));
                    exp_en[d]  = 1'b1;
                end
            end
            step();
            for (int d = 0; d < 4; d++) begin
                check(sel_strobe ? "R7 bus" : "R8 hold bus", d, int'(bus[d]), int'(exp_bus[d]));
                check("R7 en", d, int'(en[d]), int'(exp_en[d]));
                check("R7 sync", d, int'(sy[d]), 0);
                check("R7 tok", d, int'(tk[d]), 0);
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule